// File: doc/BRIEF.md
# Byte Mask and Shuffle Unit

This unit carries out two related operations that share one mask. A mask-set request adds two 64-bit integer operands and returns the 64-bit sum. As a side effect, it captures the low 32 bits of that sum in the upper half of a 64-bit graphics status register. A shuffle request builds a 64-bit result from the sixteen bytes of its two operands. Eight 4-bit selectors, taken from the captured mask, choose which source byte goes into each result byte.

A request is presented for one clock with `reqValid` high. It carries an operation code and two operands. The response appears one cycle later on `rspValid`/`rspData`. The status register is always visible on a read port. A typical sequence issues a mask-set to build a permutation, then one or more shuffles that apply it. A shuffle may follow the mask-set in the very next cycle.

Top module: `bsu_top`

## Requirements
- R1: After reset, `statusReg` is all zeros and `rspValid` is low.
- R2: A request with op code 0x019 (mask-set) produces `rspValid` high in the following cycle. `rspData` in that cycle is `opA + opB` modulo 2^64.
- R3: A mask-set writes bits 31:0 of the sum into `statusReg[63:32]`. The new value is visible in the cycle after the request.
- R4: `statusReg[31:0]` stays zero at all times.
- R5: A request with op code 0x04c (shuffle) produces `rspValid` high in the following cycle. Result byte i (`rspData[8i+7:8i]`) is chosen by selector i, which is `statusReg[32+4i+3:32+4i]`.
- R6: For the shuffle, byte k of an operand means bits 8k+7:8k. Selector values 0 to 7 pick byte `sel` of `opA`. Values 8 to 15 pick byte `sel-8` of `opB`.
- R7: A shuffle issued in the cycle right after a mask-set uses the mask written by that mask-set.
- R8: Some cycles give no response: a cycle with `reqValid` low, or with an op code other than 0x019 and 0x04c. In the cycle after one of these, `rspValid` is low, `rspData` keeps its previous value and `statusReg` is unchanged.
- R9: A shuffle leaves `statusReg` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 9 | Operation code (0x019 mask-set, 0x04c shuffle) |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| rspValid | output | 1 | Response present this cycle |
| rspData | output | 64 | Sum or shuffled result |
| statusReg | output | 64 | Graphics status register; mask in bits 63:32 |

## Verification
The two functions that meet in one cycle are the mask update and its use. A mask-set returns its sum on the same edge that writes the mask. A shuffle issued right behind it must already read that new mask. The bench provokes this with back-to-back mask-set/shuffle pairs, both directed (identity, all-`opB`, broadcast masks) and random. It judges the shuffle against a reference permutation computed from the mask its own model derived from the sum. Invalid op codes and idle cycles are mixed in to confirm that neither the mask nor the held result drifts.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  localparam int OP_W = 9;
  localparam logic [OP_W-1:0] OP_MASK_SET = 9'h019;
  localparam logic [OP_W-1:0] OP_SHUFFLE  = 9'h04c;

  typedef struct packed {
    logic maskSet;
    logic shuffle;
  } bsu_strobe_t;
endpackage

// File: rtl/bsu_ctrl.sv
module bsu_ctrl
  import bsu_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [OP_W-1:0] reqOp,
  output bsu_strobe_t     strobe,
  output logic            rspValid
);
  logic isMaskSet;
  logic isShuffle;

  always_comb begin
    isMaskSet = (reqOp == OP_MASK_SET);
    isShuffle = (reqOp == OP_SHUFFLE);
    strobe.maskSet = reqValid && isMaskSet;
    strobe.shuffle = reqValid && isShuffle;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= strobe.maskSet || strobe.shuffle;
  end
endmodule

// File: rtl/bsu_datapath.sv
module bsu_datapath
  import bsu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  bsu_strobe_t       strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] rspData,
  output logic [DATA_W-1:0] statusReg
);
  localparam int LANES  = DATA_W / LANE_W;
  localparam int MASK_W = LANES * SEL_W;
  localparam int LO_W   = DATA_W - MASK_W;
  localparam int POOL_W = 2 * DATA_W;

  logic [DATA_W-1:0] sum;
  logic [MASK_W-1:0] maskHi;
  logic [POOL_W-1:0] pool;
  logic [DATA_W-1:0] shuffled;

  assign sum  = opA + opB;
  assign pool = {opB, opA};

  // One selector per output lane; the pool spans both operands.
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic [SEL_W-1:0] sel;
    assign sel = maskHi[lane*SEL_W +: SEL_W];
    assign shuffled[lane*LANE_W +: LANE_W] = pool[sel*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) maskHi <= '0;
    else if (strobe.maskSet) maskHi <= sum[MASK_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspData <= '0;
    else if (strobe.maskSet) rspData <= sum;
    else if (strobe.shuffle) rspData <= shuffled;
  end

  assign statusReg = {maskHi, {LO_W{1'b0}}};
endmodule

// File: rtl/bsu_top.sv
module bsu_top
  import bsu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [8:0]        reqOp,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [DATA_W-1:0] statusReg
);
  bsu_strobe_t strobe;

  bsu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .strobe(strobe), .rspValid(rspValid)
  );

  bsu_datapath #(.DATA_W(DATA_W), .LANE_W(LANE_W), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opA(opA), .opB(opB),
    .rspData(rspData), .statusReg(statusReg)
  );
endmodule

// File: rtl/bsu_checker.sv
module bsu_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [8:0]  reqOp,
  input logic [63:0] opA,
  input logic [63:0] opB,
  input logic        rspValid,
  input logic [63:0] rspData,
  input logic [63:0] statusReg
);
  logic isSet, isShuf;
  assign isSet  = reqValid && (reqOp == 9'h019);
  assign isShuf = reqValid && (reqOp == 9'h04c);

  assert_sum_out_R2: assert property (@(posedge clk) disable iff (!rstN)
    isSet |=> (rspValid && rspData == $past(opA + opB)));

  assert_mask_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    isSet |=> (statusReg[63:32] == $past(opA[31:0] + opB[31:0])));

  assert_low_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    statusReg[31:0] == 32'h0);

  assert_shuffle_resp_R5: assert property (@(posedge clk) disable iff (!rstN)
    isShuf |=> rspValid);

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(isSet || isShuf) |=> (!rspValid && $stable(rspData) && $stable(statusReg)));

  assert_shuffle_keeps_status_R9: assert property (@(posedge clk) disable iff (!rstN)
    isShuf |=> $stable(statusReg));
endmodule

bind bsu_top bsu_checker u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
  .opA(opA), .opB(opB), .rspValid(rspValid), .rspData(rspData),
  .statusReg(statusReg)
);

// File: tb/bsu_top_test.sv
module bsu_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [8:0]  reqOp = '0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        rspValid;
  logic [63:0] rspData;
  logic [63:0] statusReg;

  int checks = 0;
  int fails = 0;
  logic [31:0] modelMask = '0;
  logic [63:0] modelData = '0;
  bit done = 0;

  always #10 clk = ~clk;

  bsu_top uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .opA(opA), .opB(opB), .rspValid(rspValid), .rspData(rspData),
    .statusReg(statusReg)
  );

  function automatic logic [63:0] refShuffle(logic [31:0] m, logic [63:0] a, logic [63:0] b);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      int s = int'(m[4*i +: 4]);
      r[8*i +: 8] = (s < 8) ? a[8*s +: 8] : b[8*(s-8) +: 8];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at negedge, result registered on next posedge, sampled at following negedge.
  task automatic issue(bit v, logic [8:0] op, logic [63:0] a, logic [63:0] b, string tag);
    bit resp;
    logic [63:0] sum;
    reqValid = v; reqOp = op; opA = a; opB = b;
    sum = a + b;
    resp = 0;
    if (v && op == 9'h019) begin
      modelData = sum; modelMask = sum[31:0]; resp = 1;
    end else if (v && op == 9'h04c) begin
      modelData = refShuffle(modelMask, a, b); resp = 1;
    end
    @(negedge clk);
    check({tag, " rspValid"}, {63'b0, rspValid}, {63'b0, resp});
    check({tag, " rspData"}, rspData, modelData);
    check({tag, " status R3 R4"}, statusReg, {modelMask, 32'h0});
    reqValid = 0;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 status", statusReg, 64'h0);
    check("R1 rspValid", {63'b0, rspValid}, 64'h0);
    rstN = 1'b1;

    // R2 carry crossing the 32-bit boundary and wrap past 2^64
    issue(1, 9'h019, 64'h0000_0000_FFFF_FFFF, 64'h1, "R2 carry");
    issue(1, 9'h019, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_7654_3211, "R2 wrap");
    // identity mask -> opA (R5, R6, R7 back-to-back)
    issue(1, 9'h04c, 64'h0807_0605_0403_0201, 64'hF8F7_F6F5_F4F3_F2F1, "R7 R6 identity");
    issue(1, 9'h019, 64'h0, 64'hFEDC_BA98, "R2 mask hi");
    issue(1, 9'h04c, 64'h1111_2222_3333_4444, 64'hA1B2_C3D4_E5F6_0718, "R6 all opB");
    issue(1, 9'h019, 64'h0, 64'h0, "R2 zero mask");
    issue(1, 9'h04c, 64'h0123_4567_89AB_CDEF, 64'h0, "R5 broadcast byte0");
    issue(1, 9'h019, 64'h5, 64'h0F70_8F00, "R2 mixed");
    issue(1, 9'h04c, 64'h0706_0504_0302_0100, 64'h0F0E_0D0C_0B0A_0908, "R5 mixed sel");
    // R8: invalid op, valid low with a real op code
    issue(1, 9'h01a, 64'h1, 64'h2, "R8 bad op");
    issue(0, 9'h019, 64'h33, 64'h44, "R8 no valid");
    issue(0, 9'h04c, 64'h33, 64'h44, "R8 no valid shuf");
    // R9: shuffle leaves status
    issue(1, 9'h04c, 64'hDEAD_BEEF_0000_1111, 64'h1234_5678_9ABC_DEF0, "R9 shuffle");

    for (int n = 0; n < 400; n++) begin
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      int k = int'($urandom_range(0, 9));
      if (k < 3)      issue(1, 9'h019, a, b, "R2 R3 random set");
      else if (k < 8) issue(1, 9'h04c, a, b, "R5 R6 random shuffle");
      else if (k < 9) issue(1, 9'($urandom), a, b, "R8 random op");
      else            issue(0, 9'h019, a, b, "R8 random idle");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule